// File: doc/BRIEF.md
# Enclave Lifecycle Controller

This block keeps the lifecycle state of a few isolated execution regions, called enclaves, and the execution mode of each logical core. One command per cycle comes in with an opcode, a target slot, an issuing core and a 32-bit operand.

A slot is built in a fixed sequence. A create command empties the slot. Add-page and extend commands then fold their operands into a running measurement, and some add-page commands also declare entry addresses. An initialize command seals the slot. It succeeds only when both external validity flags are set and the measurement equals the expected value that comes with the command.

After that, cores may enter the enclave at a declared entry address, within a per-enclave limit on active threads. A core leaves through a normal exit or through an interrupt. An interrupt leaves the core owing a re-entry to the same enclave. Every mode change pulses a translation-cache flush line for that core. Each command gets a registered response one cycle later, with an error flag and the slot's measurement after the command.

Top module: `enclave_lifecycle_ctrl`

## Requirements
- R1: After reset every slot is free, no core is inside an enclave, no flush line is high and no response is valid.
- R2: Create (opcode 0) on a free or building slot moves it to building, with measurement 0, no entry addresses, zero active threads and a thread limit of cmd_data[1:0]. Create on an initialized slot is rejected and leaves the slot unchanged.
- R3: The fold is m' = rotl(m,5) XOR x. Add-page (opcode 1) uses x = cmd_data XOR 32'hA5A50000 XOR cmd_entry. Extend (opcode 2) uses x = cmd_data. rsp_meas reports the addressed slot's measurement after the command, so a different order of the same operands gives a different value.
- R4: Add-page and extend are accepted only on a building slot. On any other slot they are rejected and the measurement is unchanged.
- R5: Initialize (opcode 3) succeeds only when the slot is building, cert_ok and token_ok are both high, and the measurement equals cmd_data. On any failure the slot stays building.
- R6: An accepted add-page with cmd_entry high records cmd_data as an entry address. A slot holds at most 4 entry addresses, and a fifth such add-page is rejected with no change to the slot.
- R7: Enter (opcode 4) is accepted only when the slot is initialized and cmd_data equals one of its recorded entry addresses.
- R8: Enter is rejected when the slot's active-thread count already equals its limit. Accepted enters raise the count, and accepted exits and interrupts lower the count of the slot the core was in.
- R9: Enter is rejected for a core that is already inside an enclave. Exit (opcode 5) and interrupt (opcode 6) are rejected for a core that is outside.
- R10: An accepted interrupt takes the core out of the enclave. Until the core's next accepted enter, it may enter only the slot it was interrupted in.
- R11: The issuing core's xlat_flush bit pulses for exactly one cycle, together with the mode change, for every accepted enter, exit or interrupt, and at no other time.
- R12: rsp_valid follows cmd_valid by one cycle, and rsp_err marks a rejected command. Opcode 7 is always rejected. While in_encl of a core is high, its cur_id field holds the slot it entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Opcode |
| cmd_id | input | 2 | Target slot |
| cmd_core | input | 1 | Issuing core |
| cmd_data | input | 32 | Operand: page content, entry address, expected measurement or thread limit |
| cmd_entry | input | 1 | Add-page declares cmd_data as an entry address |
| cert_ok | input | 1 | Certificate check passed |
| token_ok | input | 1 | Launch token check passed |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Command rejected |
| rsp_meas | output | 32 | Measurement of the addressed slot after the command |
| xlat_flush | output | 2 | Per-core translation-cache flush pulse |
| in_encl | output | 2 | Per-core in-enclave flag |
| cur_id | output | 4 | Per-core current slot, two bits per core |

## Verification
The assertions assume that cmd_valid is low while reset is asserted. They also assume that the inputs change only away from the rising edge, so every command is sampled once. The bench drives all inputs right after the falling edge and holds the command strobe low for the whole reset. It issues each command for exactly one cycle and compares every output against a behavioural model at the next falling edge. The stimulus covers both accepted and rejected forms of every opcode, including validity flags dropped one at a time and the pending re-entry after an interrupt.

// File: rtl/enclave_lifecycle_ctrl.sv
module enclave_lifecycle_ctrl #(
  parameter int NSLOT = 4,
  parameter int NENT  = 4,
  parameter int NCORE = 2,
  parameter int DW    = 32,
  parameter int TW    = 2,
  parameter int ROT   = 5,
  localparam int IDW  = $clog2(NSLOT),
  localparam int CW   = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [2:0]           cmd_op,
  input  logic [IDW-1:0]       cmd_id,
  input  logic [CW-1:0]        cmd_core,
  input  logic [DW-1:0]        cmd_data,
  input  logic                 cmd_entry,
  input  logic                 cert_ok,
  input  logic                 token_ok,
  output logic                 rsp_valid,
  output logic                 rsp_err,
  output logic [DW-1:0]        rsp_meas,
  output logic [NCORE-1:0]     xlat_flush,
  output logic [NCORE-1:0]     in_encl,
  output logic [NCORE*IDW-1:0] cur_id
);
  localparam int EW  = $clog2(NENT + 1);
  localparam int EIW = $clog2(NENT);
  localparam logic [2:0] OP_CREATE = 3'd0, OP_ADD = 3'd1, OP_EXT = 3'd2, OP_INIT = 3'd3,
                         OP_ENTER  = 3'd4, OP_EXIT = 3'd5, OP_INTR = 3'd6;
  localparam logic [1:0] ST_FREE = 2'd0, ST_BUILD = 2'd1, ST_READY = 2'd2;
  localparam logic [DW-1:0] ADD_SALT = DW'(32'hA5A5_0000);

  logic [1:0]     st   [NSLOT];
  logic [DW-1:0]  meas [NSLOT];
  logic [DW-1:0]  ept  [NSLOT][NENT];
  logic [EW-1:0]  ecnt [NSLOT];
  logic [TW-1:0]  tmax [NSLOT];
  logic [TW-1:0]  tcnt [NSLOT];
  logic [NCORE-1:0] inen, pend;
  logic [IDW-1:0] cur [NCORE];
  logic [IDW-1:0] pid [NCORE];

  function automatic logic [DW-1:0] fold(input logic [DW-1:0] m, input logic [DW-1:0] x);
    return {m[DW-ROT-1:0], m[DW-1:DW-ROT]} ^ x;
  endfunction

  wire [IDW-1:0] xid      = cur[cmd_core];
  wire           building = st[cmd_id] == ST_BUILD;
  wire           ready    = st[cmd_id] == ST_READY;
  wire           ent_room = ecnt[cmd_id] < EW'(NENT);
  wire           thr_room = tcnt[cmd_id] < tmax[cmd_id];
  wire           pend_ok  = !pend[cmd_core] || (pid[cmd_core] == cmd_id);
  wire [DW-1:0]  add_x    = cmd_data ^ ADD_SALT ^ DW'(cmd_entry);

  logic hit;
  always_comb begin
    hit = 1'b0;
    for (int e = 0; e < NENT; e++)
      if (EW'(e) < ecnt[cmd_id] && ept[cmd_id][e] == cmd_data) hit = 1'b1;
  end

  logic acc;
  always_comb begin
    case (cmd_op)
      OP_CREATE: acc = !ready;
      OP_ADD:    acc = building && (!cmd_entry || ent_room);
      OP_EXT:    acc = building;
      OP_INIT:   acc = building && cert_ok && token_ok && (meas[cmd_id] == cmd_data);
      OP_ENTER:  acc = ready && !inen[cmd_core] && pend_ok && thr_room && hit;
      OP_EXIT,
      OP_INTR:   acc = inen[cmd_core];
      default:   acc = 1'b0;
    endcase
  end

  wire go = cmd_valid && acc;

  logic [DW-1:0] meas_nx;
  always_comb begin
    meas_nx = meas[cmd_id];
    if (go) begin
      case (cmd_op)
        OP_CREATE: meas_nx = '0;
        OP_ADD:    meas_nx = fold(meas[cmd_id], add_x);
        OP_EXT:    meas_nx = fold(meas[cmd_id], cmd_data);
        default:   meas_nx = meas[cmd_id];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSLOT; s++) begin
        st[s]   <= ST_FREE;
        meas[s] <= '0;
        ecnt[s] <= '0;
        tmax[s] <= '0;
        tcnt[s] <= '0;
        for (int e = 0; e < NENT; e++) ept[s][e] <= '0;
      end
    end else if (go) begin
      meas[cmd_id] <= meas_nx;
      case (cmd_op)
        OP_CREATE: begin
          st[cmd_id]   <= ST_BUILD;
          ecnt[cmd_id] <= '0;
          tmax[cmd_id] <= cmd_data[TW-1:0];
          tcnt[cmd_id] <= '0;
        end
        OP_ADD: if (cmd_entry) begin
          ept[cmd_id][ecnt[cmd_id][EIW-1:0]] <= cmd_data;
          ecnt[cmd_id] <= ecnt[cmd_id] + 1'b1;
        end
        OP_INIT:  st[cmd_id]   <= ST_READY;
        OP_ENTER: tcnt[cmd_id] <= tcnt[cmd_id] + 1'b1;
        OP_EXIT,
        OP_INTR:  tcnt[xid]    <= tcnt[xid] - 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inen       <= '0;
      pend       <= '0;
      xlat_flush <= '0;
      for (int c = 0; c < NCORE; c++) begin
        cur[c] <= '0;
        pid[c] <= '0;
      end
    end else begin
      xlat_flush <= '0;
      if (go) begin
        case (cmd_op)
          OP_ENTER: begin
            inen[cmd_core]       <= 1'b1;
            pend[cmd_core]       <= 1'b0;
            cur[cmd_core]        <= cmd_id;
            xlat_flush[cmd_core] <= 1'b1;
          end
          OP_EXIT: begin
            inen[cmd_core]       <= 1'b0;
            xlat_flush[cmd_core] <= 1'b1;
          end
          OP_INTR: begin
            inen[cmd_core]       <= 1'b0;
            pend[cmd_core]       <= 1'b1;
            pid[cmd_core]        <= xid;
            xlat_flush[cmd_core] <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_meas  <= '0;
    end else begin
      rsp_valid <= cmd_valid;
      rsp_err   <= cmd_valid && !acc;
      rsp_meas  <= cmd_valid ? meas_nx : '0;
    end
  end

  assign in_encl = inen;
  for (genvar c = 0; c < NCORE; c++) begin : g_cur
    assign cur_id[c*IDW +: IDW] = inen[c] ? cur[c] : '0;
  end
endmodule

module enclave_lifecycle_chk #(
  parameter int NCORE = 2,
  parameter int CW    = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [2:0]       cmd_op,
  input logic [CW-1:0]    cmd_core,
  input logic             cert_ok,
  input logic             token_ok,
  input logic             rsp_valid,
  input logic             rsp_err,
  input logic [NCORE-1:0] xlat_flush,
  input logic [NCORE-1:0] in_encl
);
  assert_rsp_follows_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(cmd_valid));
  assert_err_has_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);
  assert_init_needs_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd3 && !(cert_ok && token_ok)) |=> rsp_err);
  assert_leave_needs_inside_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == 3'd5 || cmd_op == 3'd6) && !in_encl[cmd_core]) |=> rsp_err);
  assert_flush_on_mode_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_flush == (in_encl ^ $past(in_encl)));
  assert_single_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(xlat_flush));
  assert_reject_no_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (xlat_flush == '0));
  assert_entry_only_by_enter_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((in_encl & ~$past(in_encl)) != '0) |-> $past(cmd_valid && cmd_op == 3'd4));
  assert_intr_exits_core_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd6 && in_encl[cmd_core]) |=>
      (!in_encl[$past(cmd_core)] && xlat_flush[$past(cmd_core)]));
endmodule

bind enclave_lifecycle_ctrl enclave_lifecycle_chk #(.NCORE(NCORE), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_core(cmd_core),
  .cert_ok(cert_ok), .token_ok(token_ok), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .xlat_flush(xlat_flush), .in_encl(in_encl)
);

// File: tb/test_enclave_lifecycle_ctrl.sv
`timescale 1ns/1ps
module test_enclave_lifecycle_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [1:0]  cmd_id = '0;
  logic [0:0]  cmd_core = '0;
  logic [31:0] cmd_data = '0;
  logic        cmd_entry = 1'b0;
  logic        cert_ok = 1'b0;
  logic        token_ok = 1'b0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_meas;
  logic [1:0]  xlat_flush, in_encl;
  logic [3:0]  cur_id;

  always #10 clk = ~clk;

  enclave_lifecycle_ctrl i_enclave_lifecycle_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_id(cmd_id),
    .cmd_core(cmd_core), .cmd_data(cmd_data), .cmd_entry(cmd_entry), .cert_ok(cert_ok),
    .token_ok(token_ok), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_meas(rsp_meas),
    .xlat_flush(xlat_flush), .in_encl(in_encl), .cur_id(cur_id)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  int          m_st [4];
  logic [31:0] m_meas [4];
  logic [31:0] m_ept [4][$];
  int          m_tmax [4], m_tcnt [4];
  bit          m_in [2], m_pend [2];
  int          m_cur [2], m_pid [2];

  function automatic logic [31:0] mfold(input logic [31:0] m, input logic [31:0] x);
    return ((m << 5) | (m >> 27)) ^ x;
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input int op, input int id, input int core,
                      input logic [31:0] d, input bit ent, input bit c_ok, input bit t_ok,
                      input string tag);
    bit ok = 0;
    int fl = -1;
    bit hit = 0;
    logic [1:0] e_in;
    cmd_valid = v; cmd_op = 3'(op); cmd_id = 2'(id); cmd_core = 1'(core);
    cmd_data = d; cmd_entry = ent; cert_ok = c_ok; token_ok = t_ok;
    if (v) begin
      case (op)
        0: if (m_st[id] != 2) begin
             ok = 1; m_st[id] = 1; m_meas[id] = 0; m_ept[id].delete();
             m_tmax[id] = int'(d & 3); m_tcnt[id] = 0;
           end
        1: if (m_st[id] == 1 && (!ent || m_ept[id].size() < 4)) begin
             ok = 1; m_meas[id] = mfold(m_meas[id], d ^ 32'hA5A5_0000 ^ {31'b0, ent});
             if (ent) m_ept[id].push_back(d);
           end
        2: if (m_st[id] == 1) begin ok = 1; m_meas[id] = mfold(m_meas[id], d); end
        3: if (m_st[id] == 1 && c_ok && t_ok && m_meas[id] == d) begin ok = 1; m_st[id] = 2; end
        4: begin
             foreach (m_ept[id][k]) if (m_ept[id][k] == d) hit = 1;
             if (m_st[id] == 2 && !m_in[core] && (!m_pend[core] || m_pid[core] == id)
                 && m_tcnt[id] < m_tmax[id] && hit) begin
               ok = 1; m_in[core] = 1; m_cur[core] = id; m_pend[core] = 0; m_tcnt[id]++; fl = core;
             end
           end
        5: if (m_in[core]) begin ok = 1; m_in[core] = 0; m_tcnt[m_cur[core]]--; fl = core; end
        6: if (m_in[core]) begin
             ok = 1; m_in[core] = 0; m_pend[core] = 1; m_pid[core] = m_cur[core];
             m_tcnt[m_cur[core]]--; fl = core;
           end
        default: ok = 0;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    e_in = {m_in[1], m_in[0]};
    check(tag, "rsp_valid", 32'(rsp_valid), 32'(v));
    check(tag, "rsp_err", 32'(rsp_err), 32'(v && !ok));
    if (v) check(tag, "rsp_meas", rsp_meas, m_meas[id]);
    check(tag, "xlat_flush", 32'(xlat_flush), (fl >= 0) ? 32'(1 << fl) : 32'd0);
    check(tag, "in_encl", 32'(in_encl), 32'(e_in));
    for (int c = 0; c < 2; c++)
      if (m_in[c]) check(tag, "cur_id", 32'(cur_id[c*2 +: 2]), 32'(m_cur[c]));
    cmd_valid = 1'b0;
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 32'h0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R12 watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 4; s++) begin m_st[s] = 0; m_meas[s] = 0; m_tmax[s] = 0; m_tcnt[s] = 0; end
    for (int c = 0; c < 2; c++) begin m_in[c] = 0; m_pend[c] = 0; m_cur[c] = 0; m_pid[c] = 0; end
    repeat (3) @(negedge clk);
    check("R1", "rsp_valid", 32'(rsp_valid), 0);
    check("R1", "xlat_flush", 32'(xlat_flush), 0);
    check("R1", "in_encl", 32'(in_encl), 0);
    rst_n = 1'b1;
    idle("R1");
    step(1, 4, 0, 0, 32'h100, 0, 1, 1, "R7");
    step(1, 3, 3, 0, 32'h0, 0, 1, 1, "R5");
    step(1, 2, 3, 0, 32'h55, 0, 1, 1, "R4");

    step(1, 0, 0, 0, 32'h1, 0, 0, 0, "R2");
    step(1, 1, 0, 0, 32'h100, 1, 0, 0, "R6");
    step(1, 1, 0, 0, 32'h200, 0, 0, 0, "R3");
    step(1, 2, 0, 0, 32'h1234, 0, 0, 0, "R3");
    step(1, 3, 0, 0, m_meas[0] ^ 32'h1, 0, 1, 1, "R5");
    step(1, 3, 0, 0, m_meas[0], 0, 0, 1, "R5");
    step(1, 3, 0, 0, m_meas[0], 0, 1, 0, "R5");
    step(1, 3, 0, 0, m_meas[0], 0, 1, 1, "R5");
    step(1, 1, 0, 0, 32'h300, 1, 0, 0, "R4");
    step(1, 2, 0, 0, 32'h77, 0, 0, 0, "R4");
    step(1, 0, 0, 0, 32'h3, 0, 0, 0, "R2");

    step(1, 4, 0, 0, 32'h300, 0, 0, 0, "R7");
    step(1, 4, 0, 0, 32'h200, 0, 0, 0, "R7");
    step(1, 5, 0, 0, 32'h0, 0, 0, 0, "R9");
    step(1, 6, 0, 1, 32'h0, 0, 0, 0, "R9");
    step(1, 4, 0, 0, 32'h100, 0, 0, 0, "R11");
    step(1, 4, 0, 1, 32'h100, 0, 0, 0, "R8");
    step(1, 4, 0, 0, 32'h100, 0, 0, 0, "R9");
    step(1, 6, 0, 0, 32'h0, 0, 0, 0, "R10");
    idle("R11");
    step(1, 4, 0, 1, 32'h100, 0, 0, 0, "R8");
    step(1, 5, 0, 1, 32'h0, 0, 0, 0, "R11");

    step(1, 0, 1, 0, 32'h2, 0, 0, 0, "R2");
    for (int k = 0; k < 5; k++) step(1, 1, 1, 0, 32'h1000 + 32'(k * 16), 1, 0, 0, "R6");
    step(1, 3, 1, 0, m_meas[1], 0, 1, 1, "R5");
    step(1, 4, 1, 0, 32'h1000, 0, 0, 0, "R10");
    step(1, 4, 1, 1, 32'h1040, 0, 0, 0, "R6");
    step(1, 4, 1, 1, 32'h1030, 0, 0, 0, "R7");
    step(1, 4, 0, 0, 32'h100, 0, 0, 0, "R10");
    step(1, 5, 2, 1, 32'h0, 0, 0, 0, "R12");
    step(1, 5, 3, 0, 32'h0, 0, 0, 0, "R8");
    step(1, 4, 1, 0, 32'h1000, 0, 0, 0, "R10");
    step(1, 6, 0, 0, 32'h0, 0, 0, 0, "R10");
    step(1, 4, 0, 0, 32'h100, 0, 0, 0, "R10");
    step(1, 4, 1, 0, 32'h1010, 0, 0, 0, "R9");
    step(1, 5, 0, 0, 32'h0, 0, 0, 0, "R11");

    step(1, 0, 2, 0, 32'h1, 0, 0, 0, "R2");
    step(1, 2, 2, 0, 32'hAAAA_0001, 0, 0, 0, "R3");
    step(1, 2, 2, 0, 32'h0000_5555, 0, 0, 0, "R3");
    step(1, 0, 3, 0, 32'h1, 0, 0, 0, "R2");
    step(1, 2, 3, 0, 32'h0000_5555, 0, 0, 0, "R3");
    step(1, 2, 3, 0, 32'hAAAA_0001, 0, 0, 0, "R3");
    check("R3", "order sensitivity", 32'(m_meas[2] != m_meas[3]), 32'd1);
    step(1, 1, 2, 0, 32'h400, 1, 0, 0, "R6");
    step(1, 4, 2, 0, 32'h400, 0, 0, 0, "R7");
    step(1, 0, 2, 0, 32'h0, 0, 0, 0, "R2");
    step(1, 3, 2, 0, 32'h0, 0, 1, 1, "R5");
    step(1, 4, 2, 0, 32'h400, 0, 0, 0, "R8");
    step(1, 7, 0, 0, 32'h0, 0, 1, 1, "R12");
    idle("R12");
    idle("R12");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule